// File: doc/BRIEF.md
# Compare-Match Timer Channel

A single timer channel that counts prescaled ticks of a slow counting clock and raises an event when the count reaches a programmed compare value. The counter then restarts from zero, so one period lasts compare+1 prescaled ticks. A counter that climbs past the compare value wraps from all ones to zero and records an overflow instead of a match.

Software programs the channel through a small register port. Select code 0 is the control/status word, 1 is the counter and 2 is the compare value. The control/status word holds the prescale code, the request routing, an interrupt enable and a repeat-mode bit, plus two sticky flags. A start input gates counting. A match can drive a level interrupt, a one-cycle DMA request or nothing. Writes to the counter pass through a short synchronisation delay, measured in counting-clock ticks, before they take effect.

Top module: `cmt_channel`

## Requirements
- R1: After reset the counter reads 0, the compare register reads all ones, the control/status word reads 0, and irq_o and dma_req_o are low.
- R2: Control/status bits [2:0] select the prescale: code 4 advances the counter once per 8 tick_i pulses, 5 once per 32, 6 once per 128 and 7 on every tick_i pulse.
- R3: The counter holds while start_i is low, and also while the prescale code is 0 to 3.
- R4: A prescaled tick that finds the counter equal to the compare value sets the match flag (status bit 15) and returns the counter to 0, so one period is compare+1 prescaled ticks.
- R5: A prescaled tick that finds the counter at all ones and not equal to the compare value wraps it to 0 and sets the overflow flag (status bit 14) without setting the match flag.
- R6: A control/status write with bit 15 (or 14) at 0 clears that flag. A write with the bit at 1 leaves it unchanged. A flag set in the same cycle as a clearing write stays set.
- R7: A counter write takes effect on the second tick_i pulse after the write. Until then reads return the previous value, which keeps counting normally.
- R8: irq_o is high exactly while the match flag is set, routing bits [5:4] equal 2 and the enable bit 7 is 1.
- R9: With routing 1, dma_req_o is high for one clock cycle in the cycle after each match. Routing 0 and 3 give no request.
- R10: With repeat bit 8 at 0, the counter stops advancing while the match flag is set, and resumes once the flag is cleared.
- R11: rd_data_o returns the control/status word (select 0, zero-extended, with bits 13:9, 6 and 3 reading 0), the counter (select 1), the compare value (select 2), and 0 for select 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for writes (0 ctrl/status, 1 counter, 2 compare) |
| wr_data_i | input | CNT_W | Write data |
| rd_sel_i | input | 2 | Register select for reads |
| rd_data_o | output | CNT_W | Read data, combinational |
| start_i | input | 1 | Channel run enable |
| tick_i | input | 1 | One-cycle pulse per counting-clock period |
| irq_o | output | 1 | Level interrupt request |
| dma_req_o | output | 1 | One-cycle DMA request pulse |

## Verification
The overflow flag is the hardest state to reach from the ports. With a 32-bit counter it needs billions of ticks unless the counter is preloaded. The stimulus therefore writes a value just below all ones and a compare value below it. It waits the two tick synchronisation delay, then lets two prescaled ticks carry the counter across the wrap. A second hard case is a flag-clearing write that lands in the same cycle as a new match. The bench reaches it by using compare value 1 and ticking every cycle while it issues clearing writes back to back. A behavioural model checks every cycle against the design, so each such collision is judged.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
   localparam logic [1:0] SEL_CSR = 2'd0;
   localparam logic [1:0] SEL_CNT = 2'd1;
   localparam logic [1:0] SEL_CMP = 2'd2;

   localparam int CSR_W    = 16;
   localparam int MF_BIT   = 15;
   localparam int OF_BIT   = 14;
   localparam int REP_BIT  = 8;
   localparam int IE_BIT   = 7;
   localparam int RT_LO    = 4;
   localparam int MAX_DIV  = 128;

   typedef enum logic [1:0] {
      ROUTE_NONE = 2'd0,
      ROUTE_DMA  = 2'd1,
      ROUTE_IRQ  = 2'd2,
      ROUTE_RSV  = 2'd3
   } route_e;

   typedef struct packed {
      logic       rep;
      logic       ie;
      route_e     route;
      logic [2:0] psel;
   } ctrl_t;

   // ratio of tick pulses per counter step; 0 marks a reserved code
   function automatic int unsigned div_ratio(input logic [2:0] code);
      case (code)
         3'd4:    return 8;
         3'd5:    return 32;
         3'd6:    return 128;
         3'd7:    return 1;
         default: return 0;
      endcase
   endfunction
endpackage

// File: rtl/cmt_prescale.sv
module cmt_prescale
   import cmt_pkg::*;
#(
   parameter int MAXD = MAX_DIV
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       run_i,
   input  logic [2:0] psel_i,
   output logic       adv_o
);
   localparam int PW = $clog2(MAXD);

   logic [PW-1:0] div_q;
   logic [PW-1:0] last;
   logic          valid;
   int unsigned   ratio;

   always_comb begin
      ratio = div_ratio(psel_i);
      valid = (ratio != 0);
      last  = PW'(ratio - 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (!run_i || !valid) begin
         div_q <= '0;
      end else if (tick_i) begin
         div_q <= (div_q == last) ? '0 : div_q + 1'b1;
      end
   end

   assign adv_o = run_i && valid && tick_i && (div_q == last);
endmodule

// File: rtl/cmt_count.sv
module cmt_count #(
   parameter int CNT_W  = 32,
   parameter int WR_LAT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             adv_i,
   input  logic             wr_cnt_i,
   input  logic             wr_cmp_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cmp_o,
   output logic             match_o,
   output logic             ovf_o,
   output logic             load_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0] ld_val;
   logic             load;

   generate
      if (WR_LAT == 0) begin : g_direct
         assign load   = wr_cnt_i;
         assign ld_val = wdata_i;
      end else begin : g_sync
         localparam int LW = $clog2(WR_LAT) + 1;
         logic             pend_q;
         logic [LW-1:0]    pn_q;
         logic [CNT_W-1:0] pd_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pend_q <= 1'b0;
               pn_q   <= '0;
               pd_q   <= '0;
            end else if (wr_cnt_i) begin
               pend_q <= 1'b1;
               pn_q   <= '0;
               pd_q   <= wdata_i;
            end else if (pend_q && tick_i) begin
               if (pn_q == LW'(WR_LAT - 1)) pend_q <= 1'b0;
               else                         pn_q   <= pn_q + 1'b1;
            end
         end

         assign load   = pend_q && tick_i && !wr_cnt_i && (pn_q == LW'(WR_LAT - 1));
         assign ld_val = pd_q;
      end
   endgenerate

   assign match_o = adv_i && !load && (cnt_q == cmp_q);
   assign ovf_o   = adv_i && !load && (cnt_q == '1) && (cnt_q != cmp_q);
   assign load_o  = load;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= ld_val;
      end else if (adv_i) begin
         cnt_q <= (cnt_q == cmp_q) ? '0 : cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        cmp_q <= '1;
      else if (wr_cmp_i) cmp_q <= wdata_i;
   end

   assign cnt_o = cnt_q;
   assign cmp_o = cmp_q;
endmodule

// File: rtl/cmt_csr.sv
module cmt_csr
   import cmt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [CSR_W-1:0] wdata_i,
   input  logic             match_i,
   input  logic             ovf_i,
   output ctrl_t            ctrl_o,
   output logic             mf_o,
   output logic             irq_o,
   output logic             dma_o,
   output logic [CSR_W-1:0] csr_o
);
   ctrl_t ctrl_q;
   logic  mf_q, of_q, dma_q;
   logic  clr_mf, clr_of;

   assign clr_mf = wr_i && !wdata_i[MF_BIT];
   assign clr_of = wr_i && !wdata_i[OF_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mf_q   <= 1'b0;
         of_q   <= 1'b0;
         dma_q  <= 1'b0;
      end else begin
         if (wr_i) begin
            ctrl_q.rep   <= wdata_i[REP_BIT];
            ctrl_q.ie    <= wdata_i[IE_BIT];
            ctrl_q.route <= route_e'(wdata_i[RT_LO+1:RT_LO]);
            ctrl_q.psel  <= wdata_i[2:0];
         end
         mf_q  <= match_i | (mf_q & ~clr_mf);
         of_q  <= ovf_i   | (of_q & ~clr_of);
         dma_q <= match_i && (ctrl_q.route == ROUTE_DMA);
      end
   end

   assign irq_o  = mf_q && (ctrl_q.route == ROUTE_IRQ) && ctrl_q.ie;
   assign dma_o  = dma_q;
   assign mf_o   = mf_q;
   assign ctrl_o = ctrl_q;
   assign csr_o  = {mf_q, of_q, 5'b0, ctrl_q.rep, ctrl_q.ie, 1'b0,
                    ctrl_q.route, 1'b0, ctrl_q.psel};
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
   import cmt_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int WR_LAT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_sel_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic [1:0]       rd_sel_i,
   output logic [CNT_W-1:0] rd_data_o,
   input  logic             start_i,
   input  logic             tick_i,
   output logic             irq_o,
   output logic             dma_req_o
);
   generate
      if (CNT_W < CSR_W || CNT_W > 64) begin : g_bad_width
         $error("cmt_channel: CNT_W must lie in 16..64");
      end
      if (WR_LAT < 0 || WR_LAT > 8) begin : g_bad_lat
         $error("cmt_channel: WR_LAT must lie in 0..8");
      end
   endgenerate

   ctrl_t            ctrl_w;
   logic             mf_w, run_w, adv_w;
   logic             match_w, ovf_w, load_w;
   logic             csr_wr_w;
   logic [CNT_W-1:0] cnt_w, cmp_w;
   logic [CSR_W-1:0] csr_w;

   assign csr_wr_w = wr_en_i && (wr_sel_i == SEL_CSR);
   assign run_w    = start_i && (ctrl_w.rep || !mf_w);

   cmt_prescale #(.MAXD(MAX_DIV)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .run_i  (run_w),
      .psel_i (ctrl_w.psel),
      .adv_o  (adv_w)
   );

   cmt_count #(.CNT_W(CNT_W), .WR_LAT(WR_LAT)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .adv_i    (adv_w),
      .wr_cnt_i (wr_en_i && (wr_sel_i == SEL_CNT)),
      .wr_cmp_i (wr_en_i && (wr_sel_i == SEL_CMP)),
      .wdata_i  (wr_data_i),
      .cnt_o    (cnt_w),
      .cmp_o    (cmp_w),
      .match_o  (match_w),
      .ovf_o    (ovf_w),
      .load_o   (load_w)
   );

   cmt_csr u_csr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (csr_wr_w),
      .wdata_i (wr_data_i[CSR_W-1:0]),
      .match_i (match_w),
      .ovf_i   (ovf_w),
      .ctrl_o  (ctrl_w),
      .mf_o    (mf_w),
      .irq_o   (irq_o),
      .dma_o   (dma_req_o),
      .csr_o   (csr_w)
   );

   always_comb begin
      case (rd_sel_i)
         SEL_CSR: rd_data_o = {{(CNT_W-CSR_W){1'b0}}, csr_w};
         SEL_CNT: rd_data_o = cnt_w;
         SEL_CMP: rd_data_o = cmp_w;
         default: rd_data_o = '0;
      endcase
   end
endmodule

// File: rtl/cmt_channel_chk.sv
module cmt_channel_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             irq_o,
   input logic             dma_req_o,
   input logic [CNT_W-1:0] cnt,
   input logic             load,
   input logic             match_ev,
   input logic             mf,
   input logic             rep,
   input logic             csr_wr,
   input logic             wd15
);
   assert_dma_after_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req_o |-> $past(match_ev));

   assert_irq_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($past(match_ev) || $past(csr_wr)));

   assert_stopped_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !load) |=> $stable(cnt));

   assert_match_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      match_ev |=> (cnt == '0));

   assert_oneshot_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mf && !rep && !load) |=> $stable(cnt));

   assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mf && !(csr_wr && !wd15)) |=> mf);
endmodule

bind cmt_channel cmt_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .irq_o     (irq_o),
   .dma_req_o (dma_req_o),
   .cnt       (cnt_w),
   .load      (load_w),
   .match_ev  (match_w),
   .mf        (mf_w),
   .rep       (ctrl_w.rep),
   .csr_wr    (csr_wr_w),
   .wd15      (wr_data_i[15])
);

// File: tb/test_cmt_channel.sv
module test_cmt_channel;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [1:0]  wr_sel;
   logic [31:0] wr_data;
   logic [1:0]  rd_sel;
   logic [31:0] rd_data;
   logic        start_in;
   logic        tick;
   logic        irq;
   logic        dma;

   always #10 clk = ~clk;

   cmt_channel i_cmt_channel (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_sel_i  (wr_sel),
      .wr_data_i (wr_data),
      .rd_sel_i  (rd_sel),
      .rd_data_o (rd_data),
      .start_i   (start_in),
      .tick_i    (tick),
      .irq_o     (irq),
      .dma_req_o (dma)
   );

   int    checks = 0;
   int    errors = 0;
   string tag = "R1";
   bit    start_r = 0;
   bit    done = 0;

   // behavioural reference state
   logic [31:0] m_cnt, m_cmp, m_pd;
   int          m_pdiv, m_pn;
   bit          m_pend, m_mf, m_of, m_rep, m_ie, m_dma;
   logic [1:0]  m_route;
   logic [2:0]  m_psel;

   function automatic int ratio_of(input logic [2:0] c);
      if (c == 3'd4) return 8;
      if (c == 3'd5) return 32;
      if (c == 3'd6) return 128;
      if (c == 3'd7) return 1;
      return 0;
   endfunction

   function automatic logic [31:0] m_read(input logic [1:0] s);
      if (s == 2'd0)
         return {16'b0, m_mf, m_of, 5'b0, m_rep, m_ie, 1'b0, m_route, 1'b0, m_psel};
      if (s == 2'd1) return m_cnt;
      if (s == 2'd2) return m_cmp;
      return 32'h0;
   endfunction

   task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
      end
   endtask

   task automatic step(input bit wr, input logic [1:0] sel, input logic [31:0] d, input bit tk);
      bit          run, adv, load, mev, oev, clr_m, clr_o;
      int          r, npdiv;
      logic [31:0] ncnt;
      chk(tag, rd_data, m_read(rd_sel));
      chk(tag, {31'b0, irq}, {31'b0, m_mf && m_route == 2'd2 && m_ie});
      chk(tag, {31'b0, dma}, {31'b0, m_dma});
      wr_en = wr; wr_sel = sel; wr_data = d; tick = tk; start_in = start_r;
      run = start_r && (m_rep || !m_mf);
      r = ratio_of(m_psel);
      adv = 0;
      npdiv = m_pdiv;
      if (!run || r == 0) npdiv = 0;
      else if (tk) begin
         if (m_pdiv == r - 1) begin adv = 1; npdiv = 0; end
         else npdiv = m_pdiv + 1;
      end
      load = 0;
      if (wr && sel == 2'd1) begin m_pend = 1; m_pn = 0; m_pd = d; end
      else if (m_pend && tk) begin
         if (m_pn == 1) begin load = 1; m_pend = 0; end
         else m_pn = m_pn + 1;
      end
      mev = 0; oev = 0; ncnt = m_cnt;
      if (load) ncnt = m_pd;
      else if (adv) begin
         if (m_cnt == m_cmp) begin ncnt = 0; mev = 1; end
         else if (m_cnt == 32'hFFFF_FFFF) begin ncnt = 0; oev = 1; end
         else ncnt = m_cnt + 1;
      end
      m_dma = mev && (m_route == 2'd1);
      clr_m = wr && sel == 2'd0 && !d[15];
      clr_o = wr && sel == 2'd0 && !d[14];
      m_mf = mev | (m_mf & !clr_m);
      m_of = oev | (m_of & !clr_o);
      if (wr && sel == 2'd2) m_cmp = d;
      if (wr && sel == 2'd0) begin
         m_rep = d[8]; m_ie = d[7]; m_route = d[5:4]; m_psel = d[2:0];
      end
      m_cnt = ncnt;
      m_pdiv = npdiv;
      @(negedge clk);
   endtask

   task automatic idle(input int n, input bit tk);
      for (int i = 0; i < n; i++) step(0, 2'd0, 32'h0, tk);
   endtask

   task automatic peek(input logic [1:0] s);
      rd_sel = s;
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 2'd1;
      start_in = 0; tick = 0;
      m_cnt = 0; m_cmp = 32'hFFFF_FFFF; m_pd = 0; m_pdiv = 0; m_pn = 0;
      m_pend = 0; m_mf = 0; m_of = 0; m_rep = 0; m_ie = 0; m_dma = 0;
      m_route = 0; m_psel = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 / R11: reset state and register select codes
      tag = "R1";
      chk("R1 irq", {31'b0, irq}, 32'h0);
      chk("R1 dma", {31'b0, dma}, 32'h0);
      chk("R1 counter", rd_data, 32'h0);
      peek(2'd2); chk("R1 compare", rd_data, 32'hFFFF_FFFF);
      peek(2'd0); chk("R11 csr", rd_data, 32'h0);
      peek(2'd3); chk("R11 unused select", rd_data, 32'h0);
      peek(2'd1);

      // R4 / R8: divide-by-1, compare 4, interrupt routing
      tag = "R4";
      step(1, 2'd2, 32'd4, 0);
      step(1, 2'd0, 32'h0000_01A7, 0);
      start_r = 1;
      idle(4, 1);
      chk("R4 count before match", rd_data, 32'd4);
      step(0, 2'd0, 0, 1);
      chk("R4 restart after compare+1 ticks", rd_data, 32'd0);
      chk("R8 irq level on match", {31'b0, irq}, 32'h1);
      start_r = 0;
      idle(2, 0);

      // R6: write one keeps flag, write zero clears it
      tag = "R6";
      step(1, 2'd0, 32'h0000_81A7, 0);
      peek(2'd0); chk("R6 write one keeps flag", {31'b0, rd_data[15]}, 32'h1);
      step(1, 2'd0, 32'h0000_01A7, 0);
      chk("R6 write zero clears flag", {31'b0, rd_data[15]}, 32'h0);
      chk("R8 irq drops with flag", {31'b0, irq}, 32'h0);
      peek(2'd1);

      // R2: prescale ratios
      tag = "R2";
      step(1, 2'd0, 32'h0000_01A4, 0);
      step(1, 2'd1, 32'd0, 0);
      idle(2, 1);
      start_r = 1;
      idle(16, 1);
      chk("R2 divide by 8", rd_data, 32'd2);
      step(1, 2'd0, 32'h0000_01A5, 1);
      idle(31, 1);
      chk("R2 divide by 32", rd_data, 32'd3);
      step(1, 2'd0, 32'h0000_01A6, 1);
      idle(127, 1);
      chk("R2 divide by 128", rd_data, 32'd4);

      // R3: stop input and reserved codes hold the counter
      tag = "R3";
      start_r = 0;
      idle(20, 1);
      chk("R3 hold while stopped", rd_data, 32'd4);
      step(1, 2'd0, 32'h0000_01A0, 1);
      start_r = 1;
      idle(20, 1);
      chk("R3 hold on reserved prescale", rd_data, 32'd4);
      start_r = 0;
      idle(1, 0);

      // R7: counter write waits two counting-clock ticks
      tag = "R7";
      step(1, 2'd1, 32'd100, 0);
      chk("R7 old value right after write", rd_data, 32'd4);
      step(0, 2'd0, 0, 1);
      chk("R7 old value after first tick", rd_data, 32'd4);
      idle(3, 0);
      chk("R7 old value without ticks", rd_data, 32'd4);
      step(0, 2'd0, 0, 1);
      chk("R7 new value after second tick", rd_data, 32'd100);

      // R5: overflow from all ones without a match
      tag = "R5";
      step(1, 2'd2, 32'hFFFF_FFF0, 0);
      step(1, 2'd1, 32'hFFFF_FFFE, 0);
      idle(2, 1);
      step(1, 2'd0, 32'h0000_01A7, 0);
      start_r = 1;
      idle(2, 1);
      start_r = 0;
      chk("R5 wrap to zero", rd_data, 32'd0);
      peek(2'd0);
      chk("R5 overflow set, match clear", {30'b0, rd_data[15:14]}, 32'h1);
      chk("R8 no irq without match flag", {31'b0, irq}, 32'h0);
      step(1, 2'd0, 32'h0000_01A7, 0);
      chk("R6 overflow cleared", {30'b0, rd_data[15:14]}, 32'h0);
      peek(2'd1);

      // R9: DMA routing gives single pulses
      tag = "R9";
      step(1, 2'd2, 32'd2, 0);
      step(1, 2'd1, 32'd0, 0);
      idle(2, 1);
      step(1, 2'd0, 32'h0000_0197, 0);
      start_r = 1;
      idle(3, 1);
      chk("R9 dma pulse after match", {31'b0, dma}, 32'h1);
      chk("R8 no irq under dma routing", {31'b0, irq}, 32'h0);
      step(0, 2'd0, 0, 1);
      chk("R9 dma lasts one cycle", {31'b0, dma}, 32'h0);
      idle(6, 1);
      start_r = 0;
      idle(1, 0);

      // R10: one-shot mode halts until the flag is cleared
      tag = "R10";
      step(1, 2'd2, 32'd3, 0);
      step(1, 2'd1, 32'd0, 0);
      idle(2, 1);
      step(1, 2'd0, 32'h0000_00A7, 0);
      start_r = 1;
      idle(4, 1);
      idle(5, 1);
      chk("R10 halted at zero", rd_data, 32'd0);
      chk("R10 irq held", {31'b0, irq}, 32'h1);
      step(1, 2'd0, 32'h0000_00A7, 1);
      step(0, 2'd0, 0, 1);
      chk("R10 resumes after clear", rd_data, 32'd1);

      // R6: clearing writes colliding with fresh matches
      tag = "R6";
      step(1, 2'd2, 32'd1, 0);
      step(1, 2'd0, 32'h0000_01A7, 1);
      for (int i = 0; i < 8; i++) step(1, 2'd0, 32'h0000_01A7, 1);
      idle(4, 1);
      start_r = 0;
      idle(2, 0);

      finish_run();
   end
endmodule